// File: doc/BRIEF.md
# Breakpoint Register and Match Unit

This block holds the debug breakpoint state of a small processor core and checks every memory access and every instruction fetch against it. Four 64-bit address registers, a 64-bit control register and a 64-bit status register sit behind one register-access port. A mode input sets the access width of that port. In 32-bit mode, writes zero-fill the upper half and reads return only the lower half. In 64-bit mode, all 64 bits move. Writes in 64-bit mode that set a reserved upper bit of the control or status register are refused and raise a protection-fault flag.

On the match side, each breakpoint has an enable, a kind (instruction fetch, data write, data read-or-write) and a length of 1, 2, 4 or 8 bytes. The length defines a naturally aligned window. A data access hits when any byte it touches lies in the window. Hits are reported in the same cycle, split into fault-class (instruction hits and the register guard) and trap-class (data hits). Each hit also sets a sticky status bit that stays set until software clears it.

Top module: `bkpt_unit`

## Requirements
- R1: After synchronous reset, all six registers read as zero and `hit_vec`, `fault_hit`, `trap_hit` and `gp_fault` are low.
- R2: With `mode64`=0, a register write stores `{32'b0, wdata[31:0]}` and a read returns `{32'b0, reg[31:0]}`.
- R3: With `mode64`=1, writes and reads move all 64 bits. Any 64-bit value written to an address register (sel 0..3) is stored, with no range check.
- R4: With `mode64`=1, a write to control (sel 5) or status (sel 4) with any of `wdata[63:32]` set is not applied, and `gp_fault` is high in that cycle. The same data written with `mode64`=0 is accepted without a fault.
- R5: Register map: sel 0..3 are address registers, sel 4 is status, sel 5 is control. In control, bit n (n = 0..3) enables breakpoint n, bits 16+4n..17+4n hold its kind, and bits 18+4n..19+4n hold its length. Kind codes: 00 = instruction fetch, 01 = data write, 11 = data read or write, 10 = never matches. Length codes: 00 = 1, 01 = 2, 11 = 4, 10 = 8 bytes. Access size `acc_size` codes: 00 = 1, 01 = 2, 10 = 4, 11 = 8 bytes.
- R6: A breakpoint window starts at its address with the low length bits cleared (none, bit 0, bits 1:0 or bits 2:0) and spans the length. A data access hits when its byte range overlaps that window.
- R7: A data-write breakpoint ignores reads. A read-or-write breakpoint triggers on both. Kind 10 never hits.
- R8: An instruction breakpoint hits when `fetch_valid` is high and `fetch_addr` equals its address; this raises `fault_hit`. Data hits raise `trap_hit`. When a fetch hit and a data hit occur in the same cycle, both flags are high together.
- R9: A hit on breakpoint n sets status bit n on the next clock edge. The bit stays set until a status write clears it.
- R10: A breakpoint whose enable bit is clear never appears in `hit_vec`.
- R11: While control bit 13 is set, any register access (read or write) is blocked and raises `fault_hit` in that cycle. On the next edge, status bit 13 is set and control bit 13 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | Register access width: 1 = 64-bit, 0 = 32-bit |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select (0..3 address, 4 status, 5 control) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (zero when not reading) |
| gp_fault | output | 1 | Reserved-bit write refused (protection fault, code 0) |
| acc_valid | input | 1 | Data access present |
| acc_addr | input | 64 | Data access start address |
| acc_size | input | 2 | Data access size code |
| acc_write | input | 1 | 1 = write, 0 = read |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | 64 | Instruction fetch address |
| hit_vec | output | 4 | Breakpoints hit in this cycle |
| fault_hit | output | 1 | Fault-class condition this cycle |
| trap_hit | output | 1 | Trap-class condition this cycle |

## Verification
The hardest case to reach is an unaligned multi-byte access that only partly overlaps a window, such as an access that crosses into a window from below or a wide access whose last byte lands on the window's first byte. The stimulus places breakpoints of each length at known aligned addresses. It then walks accesses of several sizes across each window edge, so that both the hitting and the missing neighbour of every edge are driven. The guard bit is tested by arming it and then attempting a write. The register contents read back afterwards show that the write was blocked.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int XLEN   = 64;
    localparam int HALF   = XLEN / 2;
    localparam int NUM_BP = 4;
    localparam int SEL_W  = 3;
    localparam int SEL_STATUS = 4;
    localparam int SEL_CTRL   = 5;
    localparam int GUARD_BIT  = 13;
    localparam int CFG_BASE   = 16;

    typedef enum logic [1:0] {
        KIND_EXEC = 2'b00,
        KIND_WR   = 2'b01,
        KIND_NONE = 2'b10,
        KIND_RW   = 2'b11
    } bp_kind_e;

    typedef enum logic [1:0] {
        LEN_1 = 2'b00,
        LEN_2 = 2'b01,
        LEN_8 = 2'b10,
        LEN_4 = 2'b11
    } bp_len_e;

    typedef struct packed {
        logic     en;
        bp_kind_e kind;
        bp_len_e  len;
    } bp_cfg_t;

    function automatic logic [3:0] len_span(input bp_len_e l);
        case (l)
            LEN_1:   return 4'd0;
            LEN_2:   return 4'd1;
            LEN_4:   return 4'd3;
            default: return 4'd7;
        endcase
    endfunction

    function automatic logic [3:0] size_span(input logic [1:0] s);
        case (s)
            2'b00:   return 4'd0;
            2'b01:   return 4'd1;
            2'b10:   return 4'd3;
            default: return 4'd7;
        endcase
    endfunction

    function automatic bp_cfg_t decode_cfg(input logic [XLEN-1:0] ctrl, input int idx);
        bp_cfg_t c;
        c.en   = ctrl[idx];
        c.kind = bp_kind_e'(ctrl[CFG_BASE + 4*idx +: 2]);
        c.len  = bp_len_e'(ctrl[CFG_BASE + 4*idx + 2 +: 2]);
        return c;
    endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
    import bkpt_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode64,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [SEL_W-1:0]              sel,
    input  logic [XLEN-1:0]               wdata,
    input  logic [NUM_BP-1:0]             hits,
    output logic [XLEN-1:0]               rdata,
    output logic                          gp_fault,
    output logic                          guard_trip,
    output logic [NUM_BP-1:0][XLEN-1:0]   addr_q,
    output logic [XLEN-1:0]               ctrl_q,
    output logic [XLEN-1:0]               status_q
);
    logic [XLEN-1:0] wval;
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] status_d;
    logic            resv_bad;
    logic            wr_ok;

    assign guard_trip = ctrl_q[GUARD_BIT] && (wr_en || rd_en);
    assign wval       = mode64 ? wdata : {{HALF{1'b0}}, wdata[HALF-1:0]};
    assign resv_bad   = mode64 && wr_en && !guard_trip &&
                        ((sel == SEL_W'(SEL_STATUS)) || (sel == SEL_W'(SEL_CTRL))) &&
                        (|wdata[XLEN-1:HALF]);
    assign gp_fault   = resv_bad;
    assign wr_ok      = wr_en && !guard_trip && !resv_bad;

    always_comb begin
        raw = '0;
        if (sel < SEL_W'(NUM_BP))
            raw = addr_q[sel[1:0]];
        else if (sel == SEL_W'(SEL_STATUS))
            raw = status_q;
        else if (sel == SEL_W'(SEL_CTRL))
            raw = ctrl_q;
        if (!rd_en || guard_trip)
            rdata = '0;
        else
            rdata = mode64 ? raw : {{HALF{1'b0}}, raw[HALF-1:0]};
    end

    always_comb begin
        status_d = status_q;
        if (wr_ok && sel == SEL_W'(SEL_STATUS))
            status_d = wval;
        status_d[NUM_BP-1:0] = status_d[NUM_BP-1:0] | hits;
        if (guard_trip)
            status_d[GUARD_BIT] = 1'b1;
    end

    generate
        for (genvar i = 0; i < NUM_BP; i++) begin : g_addr
            always_ff @(posedge clk) begin
                if (rst)
                    addr_q[i] <= '0;
                else if (wr_ok && sel == SEL_W'(i))
                    addr_q[i] <= wval;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            status_q <= '0;
        end else begin
            status_q <= status_d;
            if (guard_trip)
                ctrl_q[GUARD_BIT] <= 1'b0;
            else if (wr_ok && sel == SEL_W'(SEL_CTRL))
                ctrl_q <= wval;
        end
    end
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
(
    input  bp_cfg_t         cfg,
    input  logic [XLEN-1:0] bp_addr,
    input  logic            acc_valid,
    input  logic [XLEN-1:0] acc_addr,
    input  logic [1:0]      acc_size,
    input  logic            acc_write,
    input  logic            fetch_valid,
    input  logic [XLEN-1:0] fetch_addr,
    output logic            data_hit,
    output logic            inst_hit
);
    logic [XLEN:0] w_lo, w_hi, a_lo, a_hi;
    logic [3:0]    wspan;
    logic          overlap;
    logic          kind_ok;

    assign wspan   = len_span(cfg.len);
    assign w_lo    = {1'b0, bp_addr & ~{{(XLEN-4){1'b0}}, wspan}};
    assign w_hi    = w_lo + {{(XLEN-3){1'b0}}, wspan};
    assign a_lo    = {1'b0, acc_addr};
    assign a_hi    = a_lo + {{(XLEN-3){1'b0}}, size_span(acc_size)};
    assign overlap = (a_lo <= w_hi) && (w_lo <= a_hi);

    always_comb begin
        case (cfg.kind)
            KIND_WR: kind_ok = acc_write;
            KIND_RW: kind_ok = 1'b1;
            default: kind_ok = 1'b0;
        endcase
    end

    assign data_hit = cfg.en && acc_valid && kind_ok && overlap;
    assign inst_hit = cfg.en && fetch_valid && (cfg.kind == KIND_EXEC) &&
                      (fetch_addr == bp_addr);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                mode64,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [XLEN-1:0]     reg_wdata,
    output logic [XLEN-1:0]     reg_rdata,
    output logic                gp_fault,
    input  logic                acc_valid,
    input  logic [XLEN-1:0]     acc_addr,
    input  logic [1:0]          acc_size,
    input  logic                acc_write,
    input  logic                fetch_valid,
    input  logic [XLEN-1:0]     fetch_addr,
    output logic [NUM_BP-1:0]   hit_vec,
    output logic                fault_hit,
    output logic                trap_hit
);
    logic [NUM_BP-1:0][XLEN-1:0] addr_q;
    logic [XLEN-1:0]             ctrl_q;
    logic [XLEN-1:0]             status_q;
    logic                        guard_trip;
    logic [NUM_BP-1:0]           d_hit;
    logic [NUM_BP-1:0]           i_hit;

    bkpt_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .mode64     (mode64),
        .wr_en      (reg_wr_en),
        .rd_en      (reg_rd_en),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .hits       (hit_vec),
        .rdata      (reg_rdata),
        .gp_fault   (gp_fault),
        .guard_trip (guard_trip),
        .addr_q     (addr_q),
        .ctrl_q     (ctrl_q),
        .status_q   (status_q)
    );

    generate
        for (genvar i = 0; i < NUM_BP; i++) begin : g_cmp
            bkpt_cmp u_cmp (
                .cfg         (decode_cfg(ctrl_q, i)),
                .bp_addr     (addr_q[i]),
                .acc_valid   (acc_valid),
                .acc_addr    (acc_addr),
                .acc_size    (acc_size),
                .acc_write   (acc_write),
                .fetch_valid (fetch_valid),
                .fetch_addr  (fetch_addr),
                .data_hit    (d_hit[i]),
                .inst_hit    (i_hit[i])
            );
        end
    endgenerate

    assign hit_vec   = d_hit | i_hit;
    assign trap_hit  = |d_hit;
    assign fault_hit = (|i_hit) || guard_trip;
endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk
    import bkpt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                mode64,
    input logic                reg_wr_en,
    input logic                reg_rd_en,
    input logic [SEL_W-1:0]    reg_sel,
    input logic [XLEN-1:0]     reg_rdata,
    input logic                gp_fault,
    input logic                acc_valid,
    input logic                fetch_valid,
    input logic [NUM_BP-1:0]   hit_vec,
    input logic                trap_hit,
    input logic                guard_trip,
    input logic [XLEN-1:0]     ctrl_q,
    input logic [XLEN-1:0]     status_q
);
    // R2
    narrow_read_chk: assert property (@(posedge clk) disable iff (rst)
        !mode64 |-> reg_rdata[XLEN-1:HALF] == '0);

    // R4
    resv_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (gp_fault && reg_sel == SEL_W'(SEL_CTRL)) |=> $stable(ctrl_q));

    // R4
    resv_mode_chk: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> (mode64 && reg_wr_en));

    // R8
    trap_src_chk: assert property (@(posedge clk) disable iff (rst)
        trap_hit |-> acc_valid);

    // R8
    hit_src_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec != '0) |-> (acc_valid || fetch_valid));

    // R9
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        hit_vec[0] |=> status_q[0]);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status_q[1] && !reg_wr_en) |=> status_q[1]);

    // R11
    guard_clear_chk: assert property (@(posedge clk) disable iff (rst)
        guard_trip |=> (!ctrl_q[GUARD_BIT] && status_q[GUARD_BIT]));

    // R11
    guard_cause_chk: assert property (@(posedge clk) disable iff (rst)
        guard_trip |-> (reg_wr_en || reg_rd_en));
endmodule

bind bkpt_unit bkpt_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode64      (mode64),
    .reg_wr_en   (reg_wr_en),
    .reg_rd_en   (reg_rd_en),
    .reg_sel     (reg_sel),
    .reg_rdata   (reg_rdata),
    .gp_fault    (gp_fault),
    .acc_valid   (acc_valid),
    .fetch_valid (fetch_valid),
    .hit_vec     (hit_vec),
    .trap_hit    (trap_hit),
    .guard_trip  (guard_trip),
    .ctrl_q      (ctrl_q),
    .status_q    (status_q)
);

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode64, reg_wr_en, reg_rd_en;
    logic [2:0]  reg_sel;
    logic [63:0] reg_wdata, reg_rdata;
    logic        gp_fault;
    logic        acc_valid, acc_write, fetch_valid;
    logic [63:0] acc_addr, fetch_addr;
    logic [1:0]  acc_size;
    logic [3:0]  hit_vec;
    logic        fault_hit, trap_hit;

    int total = 0;
    int bad = 0;
    logic cap_gp, cap_fault;

    always #4 clk = ~clk;

    bkpt_unit dut (
        .clk(clk), .rst(rst), .mode64(mode64), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gp_fault(gp_fault), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .hit_vec(hit_vec),
        .fault_hit(fault_hit), .trap_hit(trap_hit)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr_en = 0; reg_rd_en = 0; reg_sel = 0; reg_wdata = 0; mode64 = 1;
        acc_valid = 0; acc_addr = 0; acc_size = 0; acc_write = 0;
        fetch_valid = 0; fetch_addr = 0;
    endtask

    task automatic reg_write(input logic [2:0] s, input logic [63:0] d, input logic m64);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; mode64 = m64; reg_wr_en = 1;
        #1;
        cap_gp = gp_fault; cap_fault = fault_hit;
        @(negedge clk);
        idle();
    endtask

    task automatic reg_check(input string tag, input logic [2:0] s, input logic m64,
                             input logic [63:0] exp);
        @(negedge clk);
        reg_sel = s; mode64 = m64; reg_rd_en = 1;
        #1;
        check(tag, reg_rdata, exp);
        @(negedge clk);
        idle();
    endtask

    task automatic access(input string tag, input logic av, input logic [63:0] a,
                          input logic [1:0] sz, input logic w, input logic fv,
                          input logic [63:0] fa, input logic [3:0] eh,
                          input logic ef, input logic et);
        @(negedge clk);
        acc_valid = av; acc_addr = a; acc_size = sz; acc_write = w;
        fetch_valid = fv; fetch_addr = fa;
        #1;
        check({tag, " hit"}, {60'b0, hit_vec}, {60'b0, eh});
        check({tag, " fault"}, {63'b0, fault_hit}, {63'b0, ef});
        check({tag, " trap"}, {63'b0, trap_hit}, {63'b0, et});
        @(negedge clk);
        idle();
    endtask

    task automatic t_reset();
        check("R1 hit", {60'b0, hit_vec}, 64'd0);
        check("R1 flags", {61'b0, fault_hit, trap_hit, gp_fault}, 64'd0);
        for (int i = 0; i < 6; i++) reg_check("R1 reg", 3'(i), 1'b1, 64'd0);
    endtask

    task automatic t_width();
        reg_write(3'd0, 64'hFFFF_FFFF_1234_5678, 1'b0);
        reg_check("R2 zero-fill", 3'd0, 1'b1, 64'h0000_0000_1234_5678);
        reg_write(3'd1, 64'hDEAD_BEEF_0000_0010, 1'b1);
        reg_check("R2 narrow read", 3'd1, 1'b0, 64'h0000_0000_0000_0010);
        reg_check("R3 full read", 3'd1, 1'b1, 64'hDEAD_BEEF_0000_0010);
        reg_write(3'd3, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1);
        reg_check("R3 no range check", 3'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFF8);
    endtask

    task automatic t_reserved();
        reg_write(3'd5, 64'h0000_0001_0000_0001, 1'b1);
        check("R4 ctrl gp", {63'b0, cap_gp}, 64'd1);
        reg_check("R4 ctrl kept", 3'd5, 1'b1, 64'd0);
        reg_write(3'd4, 64'h8000_0000_0000_0000, 1'b1);
        check("R4 status gp", {63'b0, cap_gp}, 64'd1);
        reg_check("R4 status kept", 3'd4, 1'b1, 64'd0);
        reg_write(3'd5, 64'h0000_0001_0000_0001, 1'b0);
        check("R4 narrow no gp", {63'b0, cap_gp}, 64'd0);
        reg_check("R4 narrow applied", 3'd5, 1'b1, 64'd1);
        reg_write(3'd5, 64'd0, 1'b1);
    endtask

    task automatic t_data();
        reg_write(3'd0, 64'hA0002, 1'b1);
        reg_write(3'd1, 64'hB0002, 1'b1);
        reg_write(3'd2, 64'hC0000, 1'b1);
        reg_write(3'd4, 64'd0, 1'b1);
        // R5: bp0 write/len2, bp1 rw/len4, bp2 write/len8, enables 0..2
        reg_write(3'd5, 64'h0000_0000_09F5_0007, 1'b1);
        access("R6 wr1 A0002", 1, 64'hA0002, 2'b00, 1, 0, 0, 4'b0001, 0, 1);
        access("R7 rd1 A0002", 1, 64'hA0002, 2'b00, 0, 0, 0, 4'b0000, 0, 0);
        access("R6 wr2 A0001", 1, 64'hA0001, 2'b01, 1, 0, 0, 4'b0001, 0, 1);
        access("R6 wr1 A0001", 1, 64'hA0001, 2'b00, 1, 0, 0, 4'b0000, 0, 0);
        access("R7 rd4 A0003", 1, 64'hA0003, 2'b10, 0, 0, 0, 4'b0000, 0, 0);
        access("R6 wr1 A0003", 1, 64'hA0003, 2'b00, 1, 0, 0, 4'b0001, 0, 1);
        access("R7 rd1 B0001", 1, 64'hB0001, 2'b00, 0, 0, 0, 4'b0010, 0, 1);
        access("R6 rd2 AFFFF", 1, 64'hAFFFF, 2'b01, 0, 0, 0, 4'b0010, 0, 1);
        access("R6 wr4 B0004", 1, 64'hB0004, 2'b10, 1, 0, 0, 4'b0000, 0, 0);
        access("R6 wr2 C0006", 1, 64'hC0006, 2'b01, 1, 0, 0, 4'b0100, 0, 1);
        access("R6 wr1 C0008", 1, 64'hC0008, 2'b00, 1, 0, 0, 4'b0000, 0, 0);
        access("R6 wr8 BFFFC", 1, 64'hBFFFC, 2'b11, 1, 0, 0, 4'b0100, 0, 1);
        reg_check("R9 sticky", 3'd4, 1'b1, 64'h7);
        reg_write(3'd4, 64'd0, 1'b1);
        reg_check("R9 cleared", 3'd4, 1'b1, 64'd0);
    endtask

    task automatic t_inst();
        reg_write(3'd3, 64'h4000, 1'b1);
        reg_write(3'd5, 64'h0000_0000_09F5_000F, 1'b1);
        access("R8 fetch hit", 0, 0, 2'b00, 0, 1, 64'h4000, 4'b1000, 1, 0);
        access("R8 fetch miss", 0, 0, 2'b00, 0, 1, 64'h4001, 4'b0000, 0, 0);
        access("R8 both", 1, 64'hA0002, 2'b00, 1, 1, 64'h4000, 4'b1001, 1, 1);
        reg_check("R9 both bits", 3'd4, 1'b1, 64'h9);
        reg_write(3'd5, 64'h0000_0000_09F5_000E, 1'b1);
        access("R10 disabled", 1, 64'hA0002, 2'b00, 1, 0, 0, 4'b0000, 0, 0);
        // bp1 kind 10, len4: bits 20-21 = 10
        reg_write(3'd5, 64'h0000_0000_09E5_000E, 1'b1);
        access("R7 kind10", 1, 64'hB0001, 2'b00, 0, 0, 0, 4'b0000, 0, 0);
    endtask

    task automatic t_guard();
        reg_write(3'd0, 64'h1111, 1'b1);
        reg_write(3'd5, 64'h2000, 1'b1);
        reg_write(3'd0, 64'h5555, 1'b1);
        check("R11 fault", {63'b0, cap_fault}, 64'd1);
        check("R11 no gp", {63'b0, cap_gp}, 64'd0);
        reg_check("R11 write blocked", 3'd0, 1'b1, 64'h1111);
        reg_check("R11 guard cleared", 3'd5, 1'b1, 64'd0);
        reg_check("R11 status flag", 3'd4, 1'b1, 64'h0000_0000_0000_2009);
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_width();
        t_reserved();
        t_data();
        t_inst();
        t_guard();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule